// File: doc/BRIEF.md
# Fetch-Stage Exception Arbiter

This block sits beside the program counter in the fetch stage. For every fetch request it evaluates four fault conditions: an address breakpoint, a misaligned instruction address, a refused memory access and an undefined opcode. It then reports, one cycle later, the single condition that wins arbitration as a valid flag and a two-bit cause code.

The arbitration order is not hard-wired. Each condition carries its own compile-time priority level from 1 (strongest) to 7 (weakest), or the value OFF, which removes it from arbitration. A threshold parameter caps which levels may take part. Ties between equal levels go to the smaller cause code. Trap entry, status-register updates, flushing and the opcode decoder itself are handled elsewhere; this block only picks and reports.

Top module: `fetch_exc_select`

## Requirements
- R1: A breakpoint condition exists when `fetch_vld` is high, bit 2 of `trig_ctl` is high and `pc` equals `trig_addr`; the other bits of `trig_ctl` have no effect.
- R2: A misalignment condition exists when `fetch_vld` is high and, with `cext_en` high, `pc[0]` is 1, or, with `cext_en` low, `pc[1:0]` is nonzero.
- R3: An access-fault condition exists when `fetch_vld` is high and `mem_grant` is low.
- R4: An illegal-opcode condition exists only when `fetch_vld`, `illegal_op` and `ibuf_vld` are all high.
- R5: When no eligible condition is active, including whenever `fetch_vld` is low, `exc_vld` is 0 and `exc_cause` is 0.
- R6: Among eligible active conditions, the one with the numerically smallest level wins. Level 1 is the strongest and level 7 the weakest.
- R7: A condition whose level parameter is OFF is never reported.
- R8: A condition whose level is numerically above the `THRESH` parameter is never reported.
- R9: When eligible active conditions share the winning level, the one with the smaller cause code is reported.
- R10: Cause codes are 0 for misalignment, 1 for access fault, 2 for illegal opcode and 3 for breakpoint.
- R11: The outputs are registered. The result for inputs sampled at a rising edge appears after that edge. A synchronous low `rst_n` clears `exc_vld` and `exc_cause` to 0 at the next edge.
- R12: With default parameters the order is breakpoint (level 1), misalignment (2), access fault (3) and illegal opcode (4), with threshold 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| fetch_vld | input | 1 | A fetch is in progress this cycle |
| pc | input | XLEN | Address being fetched |
| cext_en | input | 1 | 16-bit instructions permitted (2-byte alignment) |
| trig_ctl | input | XLEN | Trigger control word; bit 2 arms the address breakpoint |
| trig_addr | input | XLEN | Breakpoint address |
| mem_grant | input | 1 | Memory accepted the fetch; low means access fault |
| illegal_op | input | 1 | Decoder flags the opcode as undefined |
| ibuf_vld | input | 1 | Instruction buffer entry holds a real instruction |
| exc_vld | output | 1 | A fault was selected for the previous cycle's fetch |
| exc_cause | output | 2 | Cause code of the selected fault |

## Verification
The bench builds six copies side by side and drives them all from the same inputs. One uses the default order. One puts misalignment first and one puts the illegal opcode first. One turns the breakpoint OFF, one lowers the threshold to level 3, and one places all four conditions at level 5. Together these reach every ordering rule: strict level order, OFF sources, the threshold cut and the tie break by cause code. A sweep of all 512 combinations of the nine input controls then compares each copy with a model that is computed in the bench. Directed cases also cover the alignment rule under each `cext_en` setting and a reset applied while a fault is present.

// File: rtl/fexc_pkg.sv
// Package: shared types and constants for the fetch exception arbiter.
// Assumes cause codes double as source indices into the condition vector.
package fexc_pkg;
    localparam int NUM_SRC = 4;
    localparam int CAUSE_W = 2;
    localparam int LVL_W   = 3;

    // Priority levels: LVL1 strongest, LVL_OFF removes the source.
    typedef enum logic [LVL_W-1:0] {
        LVL1, LVL2, LVL3, LVL4, LVL5, LVL6, LVL7, LVL_OFF
    } prio_t;

    localparam logic [CAUSE_W-1:0] CAUSE_MISAL   = 2'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_AFAULT  = 2'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 2'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_BKPT    = 2'd3;

    // True when a level may take part under the given threshold.
    function automatic logic lvl_ok(input prio_t lvl, input prio_t thr);
        return (lvl != LVL_OFF) && (lvl <= thr);
    endfunction
endpackage

// File: rtl/fexc_detect.sv
// Module: fexc_detect
// Raises one flag per fault source from the raw fetch signals.
// Assumes the condition vector is indexed by cause code.
module fexc_detect #(
    parameter int XLEN     = 32,
    parameter int TRIG_BIT = 2
) (
    input  logic                         fetch_vld,
    input  logic [XLEN-1:0]              pc,
    input  logic                         cext_en,
    input  logic                         trig_arm,
    input  logic [XLEN-1:0]              trig_addr,
    input  logic                         mem_grant,
    input  logic                         illegal_op,
    input  logic                         ibuf_vld,
    output logic [fexc_pkg::NUM_SRC-1:0] cond
);
    import fexc_pkg::*;

    logic misal_raw;

    // Alignment rule depends on whether 16-bit instructions are allowed.
    always_comb begin
        if (cext_en) misal_raw = pc[0];
        else         misal_raw = |pc[1:0];
    end

    // Gate every source with the fetch-valid flag.
    always_comb begin
        cond                = '0;
        cond[CAUSE_MISAL]   = fetch_vld && misal_raw;
        cond[CAUSE_AFAULT]  = fetch_vld && !mem_grant;
        cond[CAUSE_ILLEGAL] = fetch_vld && illegal_op && ibuf_vld;
        cond[CAUSE_BKPT]    = fetch_vld && trig_arm && (pc == trig_addr);
    end
endmodule

// File: rtl/fexc_arbiter.sv
// Module: fexc_arbiter
// Grants the active, eligible request with the smallest level; ties go to
// the smaller index. Assumes the all-ones level means "off".
module fexc_arbiter #(
    parameter int                  N      = 4,
    parameter int                  LW     = 3,
    parameter logic [N*LW-1:0]     LEVELS = '0,
    parameter logic [LW-1:0]       THRESH = {LW{1'b1}} - 1'b1
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] win,
    output logic         any
);
    localparam logic [LW-1:0] OFF = {LW{1'b1}};

    logic [N-1:0] elig;

    for (genvar gi = 0; gi < N; gi++) begin : g_src
        localparam logic [LW-1:0] MY_LVL = LEVELS[gi*LW +: LW];
        logic beaten;

        // Eligibility: request active, level not off and within threshold.
        always_comb elig[gi] = req[gi] && (MY_LVL != OFF) && (MY_LVL <= THRESH);

        // Lose if any other eligible request is stronger or ties with lower index.
        always_comb begin
            beaten = 1'b0;
            for (int j = 0; j < N; j++) begin
                if (j != gi && elig[j]) begin
                    if (LEVELS[j*LW +: LW] < MY_LVL) beaten = 1'b1;
                    if (LEVELS[j*LW +: LW] == MY_LVL && j < gi) beaten = 1'b1;
                end
            end
            win[gi] = elig[gi] && !beaten;
        end
    end

    // Summary flag: some request was granted.
    always_comb any = |elig;
endmodule

// File: rtl/fexc_encode.sv
// Module: fexc_encode
// Converts a one-hot-or-zero grant vector to a binary index; zero when idle.
module fexc_encode #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic [N-1:0] onehot,
    output logic [W-1:0] code
);
    // OR together the indices of set bits (at most one is set).
    always_comb begin
        code = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) code = code | W'(i);
        end
    end
endmodule

// File: rtl/fetch_exc_select.sv
// Module: fetch_exc_select (top)
// Detects fetch-time faults, arbitrates by per-source level parameters and
// registers the winner. Assumes cause code equals source index.
module fetch_exc_select #(
    parameter int              XLEN        = 32,
    parameter fexc_pkg::prio_t PRI_MISAL   = fexc_pkg::LVL2,
    parameter fexc_pkg::prio_t PRI_AFAULT  = fexc_pkg::LVL3,
    parameter fexc_pkg::prio_t PRI_ILLEGAL = fexc_pkg::LVL4,
    parameter fexc_pkg::prio_t PRI_BKPT    = fexc_pkg::LVL1,
    parameter fexc_pkg::prio_t THRESH      = fexc_pkg::LVL7
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fetch_vld,
    input  logic [XLEN-1:0]               pc,
    input  logic                          cext_en,
    input  logic [XLEN-1:0]               trig_ctl,
    input  logic [XLEN-1:0]               trig_addr,
    input  logic                          mem_grant,
    input  logic                          illegal_op,
    input  logic                          ibuf_vld,
    output logic                          exc_vld,
    output logic [fexc_pkg::CAUSE_W-1:0]  exc_cause
);
    import fexc_pkg::*;

    localparam int TRIG_BIT = 2;
    localparam logic [NUM_SRC*LVL_W-1:0] LEVELS =
        {PRI_BKPT, PRI_ILLEGAL, PRI_AFAULT, PRI_MISAL};
    localparam prio_t SRC_LVL [NUM_SRC] = '{PRI_MISAL, PRI_AFAULT, PRI_ILLEGAL, PRI_BKPT};

    logic [NUM_SRC-1:0] cond;
    logic [NUM_SRC-1:0] win;
    logic               win_any;
    logic [CAUSE_W-1:0] win_code;
    logic               unused_trig;

    assign unused_trig = ^{trig_ctl[XLEN-1:TRIG_BIT+1], trig_ctl[TRIG_BIT-1:0]};

    fexc_detect #(.XLEN(XLEN), .TRIG_BIT(TRIG_BIT)) u_detect (
        .fetch_vld  (fetch_vld),
        .pc         (pc),
        .cext_en    (cext_en),
        .trig_arm   (trig_ctl[TRIG_BIT]),
        .trig_addr  (trig_addr),
        .mem_grant  (mem_grant),
        .illegal_op (illegal_op),
        .ibuf_vld   (ibuf_vld),
        .cond       (cond)
    );

    fexc_arbiter #(
        .N      (NUM_SRC),
        .LW     (LVL_W),
        .LEVELS (LEVELS),
        .THRESH (THRESH)
    ) u_arb (
        .req (cond),
        .win (win),
        .any (win_any)
    );

    fexc_encode #(.N(NUM_SRC), .W(CAUSE_W)) u_enc (
        .onehot (win),
        .code   (win_code)
    );

    // Output register: clear on reset, else capture the arbitration result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_vld   <= 1'b0;
            exc_cause <= '0;
        end else begin
            exc_vld   <= win_any;
            exc_cause <= win_any ? win_code : '0;
        end
    end

    // The arbiter never grants two sources at once (tie break, R9).
    assert_single_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win));

    // Without a fetch nothing is reported on the next cycle (R5).
    assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_vld |=> (!exc_vld && exc_cause == '0));

    // An idle output always carries a zero cause (R5).
    assert_zero_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_vld |-> exc_cause == '0);

    // A refused fetch is always reported when that source can compete (R3).
    if (lvl_ok(PRI_AFAULT, THRESH)) begin : g_af_chk
        assert_fault_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (fetch_vld && !mem_grant) |=> exc_vld);
    end

    // Sources that are off (R7) or beyond threshold (R8) never appear.
    for (genvar gs = 0; gs < NUM_SRC; gs++) begin : g_mask_chk
        if (!lvl_ok(SRC_LVL[gs], THRESH)) begin : g_masked
            assert_masked_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
                exc_vld |-> exc_cause != CAUSE_W'(gs));
        end
    end
endmodule

// File: tb/tb_fetch_exc_select.sv
// Bench: six configurations driven in parallel, exhaustive sweep of input
// controls, expected results from an arithmetic model of the requirements.
module tb_fetch_exc_select;
    import fexc_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCFG       = 6;
    localparam int OFFL       = 8;   // model's "off" level

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_vld = 1'b0, cext_en = 1'b0, mem_grant = 1'b1;
    logic        illegal_op = 1'b0, ibuf_vld = 1'b0;
    logic [31:0] pc = 32'h8000_0100, trig_ctl = '0, trig_addr = '0;
    logic        vld   [NCFG];
    logic [1:0]  cause [NCFG];

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model configuration: levels per cause index {misal, afault, illegal, bkpt}.
    int lv  [NCFG][4] = '{'{2,3,4,1}, '{1,3,4,2}, '{3,4,1,2},
                          '{2,3,4,OFFL}, '{2,3,4,1}, '{5,5,5,5}};
    int thr [NCFG]    = '{7, 7, 7, 7, 3, 7};
    string tag [NCFG] = '{"R12", "R6", "R6", "R7", "R8", "R9"};

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_exc_select dut (.clk, .rst_n, .fetch_vld, .pc, .cext_en, .trig_ctl,
        .trig_addr, .mem_grant, .illegal_op, .ibuf_vld,
        .exc_vld(vld[0]), .exc_cause(cause[0]));
    fetch_exc_select #(.PRI_MISAL(LVL1), .PRI_BKPT(LVL2)) dut_mis (.clk, .rst_n,
        .fetch_vld, .pc, .cext_en, .trig_ctl, .trig_addr, .mem_grant, .illegal_op,
        .ibuf_vld, .exc_vld(vld[1]), .exc_cause(cause[1]));
    fetch_exc_select #(.PRI_ILLEGAL(LVL1), .PRI_BKPT(LVL2), .PRI_MISAL(LVL3),
        .PRI_AFAULT(LVL4)) dut_ill (.clk, .rst_n, .fetch_vld, .pc, .cext_en,
        .trig_ctl, .trig_addr, .mem_grant, .illegal_op, .ibuf_vld,
        .exc_vld(vld[2]), .exc_cause(cause[2]));
    fetch_exc_select #(.PRI_BKPT(LVL_OFF)) dut_nodbg (.clk, .rst_n, .fetch_vld,
        .pc, .cext_en, .trig_ctl, .trig_addr, .mem_grant, .illegal_op, .ibuf_vld,
        .exc_vld(vld[3]), .exc_cause(cause[3]));
    fetch_exc_select #(.THRESH(LVL3)) dut_thr (.clk, .rst_n, .fetch_vld, .pc,
        .cext_en, .trig_ctl, .trig_addr, .mem_grant, .illegal_op, .ibuf_vld,
        .exc_vld(vld[4]), .exc_cause(cause[4]));
    fetch_exc_select #(.PRI_MISAL(LVL5), .PRI_AFAULT(LVL5), .PRI_ILLEGAL(LVL5),
        .PRI_BKPT(LVL5)) dut_tie (.clk, .rst_n, .fetch_vld, .pc, .cext_en,
        .trig_ctl, .trig_addr, .mem_grant, .illegal_op, .ibuf_vld,
        .exc_vld(vld[5]), .exc_cause(cause[5]));

    task automatic compare(input string t, input int k, input logic ev, input logic [1:0] ec);
        checks++;
        if (vld[k] !== ev || cause[k] !== ec) begin
            fails++;
            $display("FAIL %s cfg%0d: vld=%0b cause=%0d expected vld=%0b cause=%0d",
                     t, k, vld[k], cause[k], ev, ec);
        end
    endtask

    // Model: pick the smallest eligible level; strict compare keeps lower cause on ties.
    task automatic model(input int k, input logic [3:0] c, output logic ev, output logic [1:0] ec);
        int best = 99;
        ev = 1'b0; ec = 2'd0;
        for (int s = 0; s < 4; s++) begin
            if (c[s] && lv[k][s] != OFFL && lv[k][s] <= thr[k] && lv[k][s] < best) begin
                best = lv[k][s]; ev = 1'b1; ec = 2'(s);
            end
        end
    endtask

    // Drive one pattern at the falling edge, sample just after the next rising edge.
    task automatic apply(input logic fv, input logic ce, input logic [1:0] plo,
                         input logic arm, input logic hit, input logic gr,
                         input logic il, input logic ib);
        @(negedge clk);
        fetch_vld = fv; cext_en = ce; mem_grant = gr; illegal_op = il; ibuf_vld = ib;
        pc        = {30'h2000_0040, plo};
        trig_ctl  = 32'hFFFF_FFFB | (32'(arm) << 2);
        trig_addr = hit ? pc : (pc ^ 32'h0000_0010);
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic ev; logic [1:0] ec;
        repeat (3) @(posedge clk);
        #1;
        for (int k = 0; k < NCFG; k++) compare("R11 reset", k, 1'b0, 2'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1: breakpoint alone, with every other trig_ctl bit set.
        apply(1, 0, 2'b00, 1, 1, 1, 0, 0);
        compare("R1 bkpt", 0, 1'b1, 2'd3);
        // R1: bit 2 clear with other bits set means no breakpoint.
        apply(1, 0, 2'b00, 0, 1, 1, 0, 0);
        compare("R1 unarmed", 0, 1'b0, 2'd0);
        // R2: 2-byte aligned pc accepted only with compressed enabled.
        apply(1, 1, 2'b10, 0, 0, 1, 0, 0);
        compare("R2 cext aligned", 0, 1'b0, 2'd0);
        apply(1, 0, 2'b10, 0, 0, 1, 0, 0);
        compare("R2 word misaligned", 0, 1'b1, 2'd0);
        apply(1, 1, 2'b01, 0, 0, 1, 0, 0);
        compare("R2 odd pc R10", 0, 1'b1, 2'd0);
        // R3 / R10: refused fetch gives cause 1.
        apply(1, 0, 2'b00, 0, 0, 0, 0, 0);
        compare("R3 afault R10", 0, 1'b1, 2'd1);
        // R4: illegal flag without buffer entry is ignored; with it gives cause 2.
        apply(1, 0, 2'b00, 0, 0, 1, 1, 0);
        compare("R4 no ibuf", 0, 1'b0, 2'd0);
        apply(1, 0, 2'b00, 0, 0, 1, 1, 1);
        compare("R4 illegal R10", 0, 1'b1, 2'd2);
        // R5: everything active but no fetch.
        apply(0, 0, 2'b11, 1, 1, 0, 1, 1);
        for (int k = 0; k < NCFG; k++) compare("R5 no fetch", k, 1'b0, 2'd0);

        // Exhaustive sweep of the nine controls across all six configurations.
        for (int v = 0; v < 512; v++) begin
            logic fv, ce, arm, hit, gr, il, ib;
            logic [1:0] plo;
            logic [3:0] c;
            {fv, ce, plo, arm, hit, gr, il, ib} = 9'(v);
            apply(fv, ce, plo, arm, hit, gr, il, ib);
            c[0] = fv && (ce ? plo[0] : (plo != 2'b00));
            c[1] = fv && !gr;
            c[2] = fv && il && ib;
            c[3] = fv && arm && hit;
            for (int k = 0; k < NCFG; k++) begin
                model(k, c, ev, ec);
                compare(ev ? tag[k] : "R5", k, ev, ec);
            end
        end

        // R11: synchronous reset while every fault is present.
        @(negedge clk);
        fetch_vld = 1; mem_grant = 0; rst_n = 1'b0;
        @(posedge clk);
        #1;
        for (int k = 0; k < NCFG; k++) compare("R11 mid reset", k, 1'b0, 2'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule